// File: doc/BRIEF.md
# Multi-Pipe Receive Acceptance Controller

This block is the primary-receiver control path of a six-pipe packet link layer. When the chip-enable input rises it counts a settling interval. Only after that interval does it look at the packets that an upstream demodulator delivers. The demodulator marks each packet with a start strobe, then sends its payload bytes, then an end strobe. The start strobe carries the index of the pipe whose address matched and a flag that asks for no acknowledgement. The end strobe carries the CRC verdict.

A packet is kept only if every condition holds:
- its pipe is enabled;
- its CRC is good;
- its byte count equals the width configured for that pipe;
- the receive FIFO has a free slot.

A kept packet goes into an internal packet FIFO, tagged with its pipe number. The receive-ready flag is set, which drives the interrupt output. The status output shows the pipe of the oldest stored packet. If auto-acknowledge is on for the pipe and the packet did not ask to skip it, the block issues a one-cycle acknowledge request. That request states whether a queued transmit payload should ride inside the acknowledge.

Dropping chip-enable puts the block back in standby at once. The FIFO can still be read byte by byte. Reading the last byte of the oldest packet removes that packet.

Top module: `rx_accept_ctrl`

## Requirements
- R1: After `ce` rises, packets whose start strobe comes before `ce` has been high for SETTLE_CYC cycles are ignored. They store nothing, set no flag and request no acknowledge.
- R2: A packet is accepted only if `pkt_pipe` is below 6, the bit `pipe_en[pkt_pipe]` is 1, and `pkt_crc_ok` is 1 on the end strobe. Any other packet is dropped with no flag and no acknowledge.
- R3: Each pipe i has a width field `pipe_width[6*i +: 6]` holding a value from 1 to 32. A packet whose byte count differs from that field, whether shorter or longer, is dropped.
- R4: An accepted packet is stored, and `rx_dr` is high from the cycle after the end strobe. `irq` is high exactly while `rx_dr` is high.
- R5: `rx_p_no` gives the pipe number of the oldest stored packet. It reads 3'b111 while the FIFO is empty.
- R6: A one-cycle pulse on `rx_dr_clr` clears `rx_dr`, and `irq` falls with it. Stored packets are not affected.
- R7: For an accepted packet on a pipe whose `auto_ack_en` bit is 1, and whose `pkt_no_ack` was 0 at the start strobe, `ack_req` is high for exactly the one cycle after the end strobe. `ack_pipe` then gives the pipe number. Otherwise no request is made.
- R8: `ack_with_pld` is high together with `ack_req` when `tx_pld_avail` was high at the end strobe, and low otherwise.
- R9: The FIFO holds FIFO_DEPTH packets (3 by default), and `rx_full` shows when it is full. A packet that ends while the FIFO is full is dropped with no flag and no acknowledge, and the stored packets are unchanged.
- R10: With `ce` low, the block is in standby and ignores all packets. The FIFO stays readable. Raising `ce` again needs a new settling interval.
- R11: `rd_data` shows the current byte of the oldest packet, and `rd_len` shows that packet's length. Each `rd_en` cycle advances one byte. After the last byte the packet is removed, and packets come out in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce | input | 1 | Chip enable; high requests active receive |
| pipe_en | input | NUM_PIPES | Per-pipe enable mask |
| auto_ack_en | input | NUM_PIPES | Per-pipe auto-acknowledge mask |
| pipe_width | input | NUM_PIPES*PW | Per-pipe payload width, 6-bit field per pipe |
| pkt_sop | input | 1 | Packet start strobe |
| pkt_pipe | input | 3 | Address-match pipe index, valid with pkt_sop |
| pkt_no_ack | input | 1 | Packet asks for no acknowledge, valid with pkt_sop |
| pkt_vld | input | 1 | Payload byte valid |
| pkt_byte | input | 8 | Payload byte |
| pkt_eop | input | 1 | Packet end strobe |
| pkt_crc_ok | input | 1 | CRC verdict, valid with pkt_eop |
| tx_pld_avail | input | 1 | A transmit payload is queued for piggybacking |
| rx_dr_clr | input | 1 | Status write that clears rx_dr |
| rd_en | input | 1 | Advance one byte of the oldest packet |
| rd_data | output | 8 | Current byte of the oldest packet |
| rd_len | output | PW | Length of the oldest packet |
| rx_empty | output | 1 | FIFO empty |
| rx_full | output | 1 | FIFO full |
| rx_p_no | output | 3 | Pipe of the oldest packet, 3'b111 when empty |
| rx_dr | output | 1 | Receive-ready status flag |
| irq | output | 1 | Interrupt, high while rx_dr is set |
| ack_req | output | 1 | One-cycle acknowledge request |
| ack_pipe | output | 3 | Pipe to acknowledge |
| ack_with_pld | output | 1 | Attach queued transmit payload to the acknowledge |

## Verification
The bench sends packets during the settling interval and while `ce` is low. A design that opened reception too early, or left it open in standby, would store those packets or raise `irq`. It tries lengths one short and one long of the configured width, and the 32-byte maximum. A saturating or off-by-one length counter would then accept a 33-byte packet or refuse a legal one. It fills the FIFO and sends one more packet, checking that nothing is overwritten or flagged. It separates the auto-acknowledge mask from the per-packet no-ack flag and from the piggyback input. A design that mixed these up would acknowledge the wrong packets or mark the payload wrongly.

// File: rtl/rx_accept_ctrl.sv
module rx_accept_ctrl #(
  parameter int NUM_PIPES  = 6,
  parameter int MAX_PLD    = 32,
  parameter int FIFO_DEPTH = 3,
  parameter int SETTLE_CYC = 130,
  localparam int PW = $clog2(MAX_PLD + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ce,
  input  logic [NUM_PIPES-1:0]    pipe_en,
  input  logic [NUM_PIPES-1:0]    auto_ack_en,
  input  logic [NUM_PIPES*PW-1:0] pipe_width,
  input  logic                    pkt_sop,
  input  logic [2:0]              pkt_pipe,
  input  logic                    pkt_no_ack,
  input  logic                    pkt_vld,
  input  logic [7:0]              pkt_byte,
  input  logic                    pkt_eop,
  input  logic                    pkt_crc_ok,
  input  logic                    tx_pld_avail,
  input  logic                    rx_dr_clr,
  input  logic                    rd_en,
  output logic [7:0]              rd_data,
  output logic [PW-1:0]           rd_len,
  output logic                    rx_empty,
  output logic                    rx_full,
  output logic [2:0]              rx_p_no,
  output logic                    rx_dr,
  output logic                    irq,
  output logic                    ack_req,
  output logic [2:0]              ack_pipe,
  output logic                    ack_with_pld
);
  localparam int LW   = $clog2(MAX_PLD + 2);
  localparam int SW   = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CW   = $clog2(FIFO_DEPTH + 1);
  localparam int AW   = $clog2(FIFO_DEPTH * MAX_PLD);
  localparam int TW   = $clog2(SETTLE_CYC + 1);
  localparam int MEMN = FIFO_DEPTH * MAX_PLD;

  // settling timer
  logic [TW-1:0] settle_cnt;
  logic          rx_on;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                 settle_cnt <= '0;
    else if (!ce)                               settle_cnt <= '0;
    else if (settle_cnt != TW'(SETTLE_CYC))     settle_cnt <= settle_cnt + 1'b1;

  assign rx_on = ce && (settle_cnt == TW'(SETTLE_CYC));

  // packet tracking
  logic          in_pkt, cur_noack;
  logic [2:0]    cur_pipe;
  logic [LW-1:0] cur_len;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      in_pkt    <= 1'b0;
      cur_noack <= 1'b0;
      cur_pipe  <= '0;
      cur_len   <= '0;
    end else if (!rx_on) begin
      in_pkt <= 1'b0;
    end else if (pkt_sop) begin
      in_pkt    <= 1'b1;
      cur_pipe  <= pkt_pipe;
      cur_noack <= pkt_no_ack;
      cur_len   <= '0;
    end else if (pkt_eop) begin
      in_pkt <= 1'b0;
    end else if (in_pkt && pkt_vld && cur_len <= LW'(MAX_PLD)) begin
      cur_len <= cur_len + 1'b1;
    end

  logic [PW-1:0] want_len;
  logic          pipe_ok, ack_ok;

  always_comb begin
    want_len = '0;
    pipe_ok  = 1'b0;
    ack_ok   = 1'b0;
    for (int i = 0; i < NUM_PIPES; i++)
      if (cur_pipe == 3'(i)) begin
        want_len = pipe_width[i*PW +: PW];
        pipe_ok  = pipe_en[i];
        ack_ok   = auto_ack_en[i];
      end
  end

  logic accept, wr_byte, pop;

  assign accept = rx_on && in_pkt && pkt_eop && pkt_crc_ok && pipe_ok && !rx_full &&
                  (cur_len == LW'(want_len)) && (cur_len != '0);
  assign wr_byte = rx_on && in_pkt && pkt_vld && !pkt_sop && !pkt_eop && !rx_full &&
                   (cur_len < LW'(MAX_PLD));

  // packet FIFO
  logic [7:0]    mem [MEMN];
  logic [PW-1:0] slot_len  [FIFO_DEPTH];
  logic [2:0]    slot_pipe [FIFO_DEPTH];
  logic [SW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic [PW-1:0] rd_idx;
  logic [AW-1:0] wr_addr, rd_addr;

  function automatic logic [SW-1:0] nxt(input logic [SW-1:0] p);
    return (p == SW'(FIFO_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign wr_addr = AW'(wr_ptr) * AW'(MAX_PLD) + AW'(cur_len);
  assign rd_addr = AW'(rd_ptr) * AW'(MAX_PLD) + AW'(rd_idx);

  always_ff @(posedge clk)
    if (wr_byte) mem[wr_addr] <= pkt_byte;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < FIFO_DEPTH; i++) begin
        slot_len[i]  <= '0;
        slot_pipe[i] <= '0;
      end
    end else if (accept) begin
      slot_len[wr_ptr]  <= want_len;
      slot_pipe[wr_ptr] <= cur_pipe;
    end

  assign rx_empty = (count == '0);
  assign rx_full  = (count == CW'(FIFO_DEPTH));
  assign pop      = rd_en && !rx_empty && (rd_idx == slot_len[rd_ptr] - 1'b1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      rd_idx <= '0;
    end else begin
      if (accept) wr_ptr <= nxt(wr_ptr);
      if (pop) begin
        rd_ptr <= nxt(rd_ptr);
        rd_idx <= '0;
      end else if (rd_en && !rx_empty) begin
        rd_idx <= rd_idx + 1'b1;
      end
      case ({accept, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end

  assign rd_data = mem[rd_addr];
  assign rd_len  = rx_empty ? '0 : slot_len[rd_ptr];
  assign rx_p_no = rx_empty ? 3'b111 : slot_pipe[rd_ptr];

  // status and acknowledge
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_dr        <= 1'b0;
      ack_req      <= 1'b0;
      ack_pipe     <= '0;
      ack_with_pld <= 1'b0;
    end else begin
      if (accept)         rx_dr <= 1'b1;
      else if (rx_dr_clr) rx_dr <= 1'b0;
      ack_req      <= accept && ack_ok && !cur_noack;
      ack_with_pld <= accept && ack_ok && !cur_noack && tx_pld_avail;
      if (accept) ack_pipe <= cur_pipe;
    end

  assign irq = rx_dr;
endmodule

// File: rtl/rx_accept_ctrl_chk.sv
module rx_accept_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ce,
  input logic       pkt_eop,
  input logic       pkt_crc_ok,
  input logic       rx_empty,
  input logic       rx_full,
  input logic [2:0] rx_p_no,
  input logic       rx_dr,
  input logic       irq,
  input logic       ack_req,
  input logic       ack_with_pld
);
  // R4
  rx_dr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_dr) |-> $past(pkt_eop && pkt_crc_ok && ce));

  // R4
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> !rx_dr);

  // R5
  empty_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_empty |-> rx_p_no == 3'b111);

  // R7
  ack_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |-> $past(pkt_eop && pkt_crc_ok && ce));

  // R7
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |=> !ack_req);

  // R8
  pld_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_with_pld |-> ack_req);

  // R9
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && pkt_eop) |=> !ack_req);

  // R10
  ce_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> (!ack_req && !$rose(rx_dr)));

  // R11
  fifo_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_full && rx_empty));
endmodule

bind rx_accept_ctrl rx_accept_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ce(ce), .pkt_eop(pkt_eop), .pkt_crc_ok(pkt_crc_ok),
  .rx_empty(rx_empty), .rx_full(rx_full), .rx_p_no(rx_p_no), .rx_dr(rx_dr),
  .irq(irq), .ack_req(ack_req), .ack_with_pld(ack_with_pld)
);

// File: tb/rx_accept_ctrl_bench.sv
`timescale 1ns/1ps
module rx_accept_ctrl_bench;
  localparam int SETTLE = 20;
  localparam int PW = 6;

  logic clk = 1'b0, rst_n = 1'b0, ce = 1'b0;
  logic [5:0] pipe_en = 6'b111111, auto_ack_en = 6'b111111;
  logic [35:0] pipe_width;
  logic pkt_sop = 0, pkt_no_ack = 0, pkt_vld = 0, pkt_eop = 0, pkt_crc_ok = 0;
  logic [2:0] pkt_pipe = 0;
  logic [7:0] pkt_byte = 0;
  logic tx_pld_avail = 0, rx_dr_clr = 0, rd_en = 0;
  logic [7:0] rd_data;
  logic [PW-1:0] rd_len;
  logic rx_empty, rx_full, rx_dr, irq, ack_req, ack_with_pld;
  logic [2:0] rx_p_no, ack_pipe;

  int n_tests = 0, n_fail = 0;
  int ack_cnt = 0, last_ack_pipe = 0, last_ack_pld = 0;
  bit done = 0;

  // widths per pipe: 4, 8, 4, 1, 32, 3
  assign pipe_width = {6'd3, 6'd32, 6'd1, 6'd4, 6'd8, 6'd4};

  rx_accept_ctrl #(.SETTLE_CYC(SETTLE)) u_rx_accept_ctrl (
    .clk(clk), .rst_n(rst_n), .ce(ce), .pipe_en(pipe_en), .auto_ack_en(auto_ack_en),
    .pipe_width(pipe_width), .pkt_sop(pkt_sop), .pkt_pipe(pkt_pipe), .pkt_no_ack(pkt_no_ack),
    .pkt_vld(pkt_vld), .pkt_byte(pkt_byte), .pkt_eop(pkt_eop), .pkt_crc_ok(pkt_crc_ok),
    .tx_pld_avail(tx_pld_avail), .rx_dr_clr(rx_dr_clr), .rd_en(rd_en), .rd_data(rd_data),
    .rd_len(rd_len), .rx_empty(rx_empty), .rx_full(rx_full), .rx_p_no(rx_p_no), .rx_dr(rx_dr),
    .irq(irq), .ack_req(ack_req), .ack_pipe(ack_pipe), .ack_with_pld(ack_with_pld));

  always #2 clk = ~clk;

  always @(posedge clk)
    if (ack_req) begin
      ack_cnt++;
      last_ack_pipe = int'(ack_pipe);
      last_ack_pld  = int'(ack_with_pld);
    end

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input int p, input bit na, input int n, input bit crc, input int base);
    @(negedge clk); pkt_sop = 1; pkt_pipe = 3'(p); pkt_no_ack = na;
    @(negedge clk); pkt_sop = 0;
    for (int k = 0; k < n; k++) begin
      pkt_vld = 1; pkt_byte = 8'(base + k); @(negedge clk);
    end
    pkt_vld = 0; pkt_eop = 1; pkt_crc_ok = crc;
    @(negedge clk); pkt_eop = 0; pkt_crc_ok = 0;
    @(negedge clk);
  endtask

  task automatic read_pkt(input string req, input int p, input int n, input int base);
    check({req, " pipe"}, int'(rx_p_no), p);
    check({req, " len"}, int'(rd_len), n);
    for (int k = 0; k < n; k++) begin
      if (rd_data != 8'(base + k)) check({req, " byte"}, int'(rd_data), (base + k) & 255);
      rd_en = 1; @(negedge clk);
    end
    rd_en = 0;
  endtask

  task automatic clear_dr();
    @(negedge clk); rx_dr_clr = 1; @(negedge clk); rx_dr_clr = 0;
  endtask

  task automatic t_reset();
    check("R5 reset empty code", int'(rx_p_no), 7);
    check("R4 reset rx_dr", int'(rx_dr), 0);
    check("R4 reset irq", int'(irq), 0);
    check("R11 reset empty", int'(rx_empty), 1);
  endtask

  task automatic t_settle();
    int a0;
    @(negedge clk); ce = 1;
    repeat (3) @(negedge clk);
    a0 = ack_cnt;
    send(0, 0, 4, 1, 8'h10);
    check("R1 early packet no flag", int'(rx_dr), 0);
    check("R1 early packet not stored", int'(rx_empty), 1);
    check("R1 early packet no ack", ack_cnt - a0, 0);
    repeat (SETTLE) @(negedge clk);
    send(0, 0, 4, 1, 8'h10);
    check("R1 settled packet stored", int'(rx_empty), 0);
    check("R4 rx_dr set", int'(rx_dr), 1);
    check("R4 irq set", int'(irq), 1);
    read_pkt("R11 settled", 0, 4, 8'h10);
    clear_dr();
    check("R6 rx_dr cleared", int'(rx_dr), 0);
    check("R6 irq cleared", int'(irq), 0);
  endtask

  task automatic t_ack();
    int a0 = ack_cnt;
    tx_pld_avail = 1;
    send(2, 0, 4, 1, 8'h20);
    check("R7 ack issued", ack_cnt - a0, 1);
    check("R7 ack pipe", last_ack_pipe, 2);
    check("R8 piggyback set", last_ack_pld, 1);
    check("R5 pipe reported", int'(rx_p_no), 2);
    tx_pld_avail = 0;
    send(5, 0, 3, 1, 8'h30);
    check("R7 second ack", ack_cnt - a0, 2);
    check("R7 ack pipe 5", last_ack_pipe, 5);
    check("R8 piggyback clear", last_ack_pld, 0);
    send(3, 1, 1, 1, 8'h40);
    check("R7 no-ack flag suppresses", ack_cnt - a0, 2);
    read_pkt("R11 order a", 2, 4, 8'h20);
    read_pkt("R11 order b", 5, 3, 8'h30);
    check("R7 no-ack packet still stored", int'(rx_p_no), 3);
    read_pkt("R11 order c", 3, 1, 8'h40);
    auto_ack_en = 6'b111110;
    send(0, 0, 4, 1, 8'h50);
    check("R7 mask off no ack", ack_cnt - a0, 2);
    check("R7 mask off stored", int'(rx_p_no), 0);
    read_pkt("R11 mask off", 0, 4, 8'h50);
    auto_ack_en = 6'b111111;
    clear_dr();
    check("R5 empty code", int'(rx_p_no), 7);
  endtask

  task automatic t_reject();
    int a0 = ack_cnt;
    send(1, 0, 8, 0, 8'h60);
    check("R2 bad crc dropped", int'(rx_empty), 1);
    pipe_en = 6'b111101;
    send(1, 0, 8, 1, 8'h60);
    check("R2 disabled pipe dropped", int'(rx_empty), 1);
    pipe_en = 6'b111111;
    send(6, 0, 4, 1, 8'h60);
    check("R2 pipe 6 dropped", int'(rx_empty), 1);
    send(7, 0, 4, 1, 8'h60);
    check("R2 pipe 7 dropped", int'(rx_empty), 1);
    send(1, 0, 7, 1, 8'h60);
    check("R3 short dropped", int'(rx_empty), 1);
    send(1, 0, 9, 1, 8'h60);
    check("R3 long dropped", int'(rx_empty), 1);
    send(4, 0, 33, 1, 8'h60);
    check("R3 over max dropped", int'(rx_empty), 1);
    check("R2 no flag on drops", int'(rx_dr), 0);
    check("R2 no ack on drops", ack_cnt - a0, 0);
    send(4, 0, 32, 1, 8'h80);
    check("R3 max width accepted", int'(rx_dr), 1);
    read_pkt("R3 max width data", 4, 32, 8'h80);
    send(1, 0, 8, 1, 8'hA0);
    read_pkt("R3 exact width data", 1, 8, 8'hA0);
    clear_dr();
  endtask

  task automatic t_full();
    int a0;
    send(0, 0, 4, 1, 8'h01);
    send(1, 0, 8, 1, 8'h11);
    send(5, 0, 3, 1, 8'h21);
    check("R9 full flag", int'(rx_full), 1);
    clear_dr();
    a0 = ack_cnt;
    send(2, 0, 4, 1, 8'h31);
    check("R9 full drop no flag", int'(rx_dr), 0);
    check("R9 full drop no ack", ack_cnt - a0, 0);
    read_pkt("R9 head kept", 0, 4, 8'h01);
    check("R9 not full after pop", int'(rx_full), 0);
    read_pkt("R9 second kept", 1, 8, 8'h11);
    read_pkt("R9 third kept", 5, 3, 8'h21);
    check("R11 drained", int'(rx_empty), 1);
  endtask

  task automatic t_ce();
    int a0;
    send(3, 0, 1, 1, 8'h77);
    @(negedge clk); ce = 0;
    a0 = ack_cnt;
    clear_dr();
    send(0, 0, 4, 1, 8'h90);
    check("R10 standby ignores packet", int'(rx_dr), 0);
    check("R10 standby no ack", ack_cnt - a0, 0);
    read_pkt("R10 readable in standby", 3, 1, 8'h77);
    check("R10 standby drained", int'(rx_empty), 1);
    @(negedge clk); ce = 1;
    repeat (3) @(negedge clk);
    send(0, 0, 4, 1, 8'h90);
    check("R10 resettle required", int'(rx_empty), 1);
    repeat (SETTLE) @(negedge clk);
    send(0, 0, 4, 1, 8'h90);
    check("R10 active after resettle", int'(rx_p_no), 0);
    read_pkt("R10 resettle data", 0, 4, 8'h90);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_settle();
    t_ack();
    t_reject();
    t_full();
    t_ce();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule